// File: doc/BRIEF.md
# DS2 Alarm Indication Signal Detector and Generator

The block watches a received DS2 bit stream for an alarm indication signal. It cuts the enabled receive bits into fixed windows of 3156 bits and counts the zeros in each one. A window qualifies when it holds fewer zeros than a selected threshold, and when the framer reported out-of-frame for every bit in it. The alarm is raised once a programmed number of qualifying windows have arrived back to back. It drops when a window fails, or as soon as the framer regains frame.

On the transmit side, a mux with its own enable replaces the outgoing DS2 stream with a constant unframed all-ones pattern. The framer sits outside the block and supplies the out-of-frame flag.

Top module: `ds2_ais_unit`

## Requirements
- R1: After reset is released, `ais_o` is 0.
- R2: A window is 3156 bits with `rx_en_i` high. Cycles with `rx_en_i` low are not counted, and the window closes only when its 3156th enabled bit arrives.
- R3: With `thr_sel_i` = 0, a window qualifies only if it holds at most 2 zeros. A window with exactly 3 zeros fails.
- R4: With `thr_sel_i` = 1, a window qualifies only if it holds at most 8 zeros. A window with exactly 9 zeros fails.
- R5: If `oof_i` is 0 on any enabled bit of a window, that window fails.
- R6: `ais_o` goes to 1 two cycles after the last bit of a qualifying window, once N consecutive windows have qualified. N is `interval_i`, and a value of 0 counts as 1. Before then it stays 0.
- R7: A failing window clears `ais_o` two cycles after its last bit and restarts the consecutive count from zero.
- R8: When `oof_i` is 0, `ais_o` is 0 in the next cycle.
- R9: When `tx_ais_en_i` is 1, `tx_data_o` is 1 in the same cycle. Otherwise `tx_data_o` equals `tx_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Received DS2 data bit |
| rx_en_i | input | 1 | High when rx_bit_i holds a valid bit |
| oof_i | input | 1 | Out-of-frame flag from the DS2 framer |
| thr_sel_i | input | 1 | Zero threshold select: 0 gives 3, 1 gives 9 |
| interval_i | input | IVL_W | Number of consecutive qualifying windows required |
| ais_o | output | 1 | Alarm indication signal detected |
| tx_ais_en_i | input | 1 | Force the transmit stream to all ones |
| tx_data_i | input | 1 | Outgoing DS2 data bit |
| tx_data_o | output | 1 | Transmitted bit |

## Verification
The assertions assume that `thr_sel_i` and `interval_i` stay constant within a window. They also assume that a window-end pulse can only follow an enabled bit. The stimulus changes the threshold and the interval only while the block is held in reset, so every window is judged against a single setting. The tasks send zeros at the start of a window and drop out-of-frame for one mid-window bit. This makes each window's outcome easy to predict at its closing edge.

// File: rtl/ds2_ais_pkg.sv
package ds2_ais_pkg;
  localparam int unsigned ZW     = 4;
  localparam int unsigned THR_LO = 3;
  localparam int unsigned THR_HI = 9;
endpackage

// File: rtl/ds2_ais_window.sv
module ds2_ais_window
  import ds2_ais_pkg::*;
#(
  parameter int unsigned WIN_LEN = 3156
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_bit_i,
  input  logic rx_en_i,
  input  logic oof_i,
  input  logic thr_sel_i,
  output logic win_done_o,
  output logic win_ok_o
);
  localparam int unsigned WCW = $clog2(WIN_LEN);
  localparam logic [WCW-1:0] WLAST = WCW'(WIN_LEN - 1);

  logic [WCW-1:0] wcnt_q;
  logic [ZW-1:0]  zcnt_q, z_now, thr;
  logic           inframe_q, bad_now, last;

  assign thr     = thr_sel_i ? ZW'(THR_HI) : ZW'(THR_LO);
  assign last    = (wcnt_q == WLAST);
  assign bad_now = inframe_q | ~oof_i;

  // saturating zero count, capped at the active threshold
  always_comb begin
    z_now = zcnt_q;
    if (!rx_bit_i && zcnt_q < thr) z_now = zcnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q     <= '0;
      zcnt_q     <= '0;
      inframe_q  <= 1'b0;
      win_done_o <= 1'b0;
      win_ok_o   <= 1'b0;
    end else begin
      win_done_o <= 1'b0;
      if (rx_en_i) begin
        if (last) begin
          win_done_o <= 1'b1;
          win_ok_o   <= (z_now < thr) && !bad_now;
          wcnt_q     <= '0;
          zcnt_q     <= '0;
          inframe_q  <= 1'b0;
        end else begin
          wcnt_q    <= wcnt_q + 1'b1;
          zcnt_q    <= z_now;
          inframe_q <= bad_now;
        end
      end
    end
  end
endmodule

// File: rtl/ds2_ais_persist.sv
module ds2_ais_persist #(
  parameter int unsigned IVL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_done_i,
  input  logic             win_ok_i,
  input  logic             oof_i,
  input  logic [IVL_W-1:0] interval_i,
  output logic             ais_o
);
  logic [IVL_W-1:0] run_q, run_nxt, ivl_eff;

  assign ivl_eff = (interval_i == '0) ? IVL_W'(1) : interval_i;
  assign run_nxt = (run_q == '1) ? run_q : run_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      ais_o <= 1'b0;
    end else begin
      if (win_done_i) begin
        if (win_ok_i) begin
          run_q <= run_nxt;
          if (run_nxt >= ivl_eff) ais_o <= 1'b1;
        end else begin
          run_q <= '0;
          ais_o <= 1'b0;
        end
      end
      if (!oof_i) ais_o <= 1'b0;  // in-frame clears with priority
    end
  end
endmodule

// File: rtl/ds2_ais_txmux.sv
module ds2_ais_txmux (
  input  logic force_i,
  input  logic data_i,
  output logic data_o
);
  assign data_o = force_i | data_i;
endmodule

// File: rtl/ds2_ais_unit.sv
module ds2_ais_unit #(
  parameter int unsigned WIN_LEN = 3156,
  parameter int unsigned IVL_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_bit_i,
  input  logic             rx_en_i,
  input  logic             oof_i,
  input  logic             thr_sel_i,
  input  logic [IVL_W-1:0] interval_i,
  output logic             ais_o,
  input  logic             tx_ais_en_i,
  input  logic             tx_data_i,
  output logic             tx_data_o
);
  logic win_done, win_ok;

  ds2_ais_window #(.WIN_LEN(WIN_LEN)) u_win (
    .clk_i, .rst_ni, .rx_bit_i, .rx_en_i, .oof_i, .thr_sel_i,
    .win_done_o(win_done), .win_ok_o(win_ok)
  );

  ds2_ais_persist #(.IVL_W(IVL_W)) u_per (
    .clk_i, .rst_ni, .win_done_i(win_done), .win_ok_i(win_ok),
    .oof_i, .interval_i, .ais_o
  );

  ds2_ais_txmux u_tx (.force_i(tx_ais_en_i), .data_i(tx_data_i), .data_o(tx_data_o));
endmodule

// File: rtl/ds2_ais_chk.sv
module ds2_ais_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_en_i,
  input logic oof_i,
  input logic tx_ais_en_i,
  input logic tx_data_i,
  input logic tx_data_o,
  input logic ais_o,
  input logic win_done,
  input logic win_ok
);
  AST_TX_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ais_en_i |-> tx_data_o);  // R9
  AST_TX_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_ais_en_i |-> (tx_data_o == tx_data_i));  // R9
  AST_INFRAME_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oof_i |=> !ais_o);  // R8
  AST_RISE_AFTER_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ais_o) |-> $past(win_done && win_ok));  // R6
  AST_FAIL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_done && !win_ok) |=> !ais_o);  // R7
  AST_DONE_ON_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_done |-> $past(rx_en_i));  // R2
endmodule

bind ds2_ais_unit ds2_ais_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_en_i(rx_en_i), .oof_i(oof_i),
  .tx_ais_en_i(tx_ais_en_i), .tx_data_i(tx_data_i), .tx_data_o(tx_data_o),
  .ais_o(ais_o), .win_done(win_done), .win_ok(win_ok)
);

// File: tb/ds2_ais_unit_bench.sv
`timescale 1ns/1ps
module ds2_ais_unit_bench;
  localparam int WIN = 3156;
  localparam int IW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b1, rx_en = 1'b0, oof = 1'b1, thr_sel = 1'b0;
  logic [IW-1:0] ivl = 8'd3;
  logic tx_en = 1'b0, tx_d = 1'b0;
  logic ais, tx_q;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ds2_ais_unit #(.WIN_LEN(WIN), .IVL_W(IW)) u_ds2_ais_unit (
    .clk_i(clk), .rst_ni(rst_n), .rx_bit_i(rx_bit), .rx_en_i(rx_en),
    .oof_i(oof), .thr_sel_i(thr_sel), .interval_i(ivl), .ais_o(ais),
    .tx_ais_en_i(tx_en), .tx_data_i(tx_d), .tx_data_o(tx_q)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic ts, input logic [IW-1:0] iv);
    rst_n = 1'b0; rx_en = 1'b0; oof = 1'b1; thr_sel = ts; ivl = iv;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // n enabled bits; the first nz are zeros; bit index ifpos is sent in frame
  task automatic send_bits(input int n, input int nz, input int ifpos, input bit gap);
    for (int i = 0; i < n; i++) begin
      rx_en = 1'b1; rx_bit = (i < nz) ? 1'b0 : 1'b1; oof = (i == ifpos) ? 1'b0 : 1'b1;
      @(negedge clk);
      if (gap) begin rx_en = 1'b0; oof = 1'b1; @(negedge clk); end
    end
    rx_en = 1'b0; oof = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(1'b0, 8'd3);
    chk("R1 reset ais", ais, 1'b0);
  endtask

  task automatic t_thr3;
    do_reset(1'b0, 8'd3);
    send_bits(WIN, 2, -1, 0); chk("R6 first of 3", ais, 1'b0);
    send_bits(WIN, 2, -1, 0); chk("R6 second of 3", ais, 1'b0);
    send_bits(WIN, 2, -1, 0); chk("R3 R6 third declares", ais, 1'b1);
    send_bits(WIN, 3, -1, 0); chk("R3 R7 three zeros clears", ais, 1'b0);
    send_bits(WIN, 0, -1, 0); chk("R7 restart 1", ais, 1'b0);
    send_bits(WIN, 1, -1, 0); chk("R7 restart 2", ais, 1'b0);
    send_bits(WIN, 0, -1, 0); chk("R7 restart 3 declares", ais, 1'b1);
  endtask

  task automatic t_thr9;
    do_reset(1'b1, 8'd1);
    send_bits(WIN, 8, -1, 0); chk("R4 eight zeros", ais, 1'b1);
    send_bits(WIN, 9, -1, 0); chk("R4 nine zeros", ais, 1'b0);
    do_reset(1'b0, 8'd0);
    send_bits(WIN, 0, -1, 0); chk("R6 interval zero as one", ais, 1'b1);
  endtask

  task automatic t_inframe;
    do_reset(1'b0, 8'd1);
    send_bits(WIN, 0, 1500, 0); chk("R5 in-frame bit fails window", ais, 1'b0);
    send_bits(WIN, 0, -1, 0);   chk("R5 clean window declares", ais, 1'b1);
    oof = 1'b0; @(negedge clk);
    chk("R8 in frame clears", ais, 1'b0);
    oof = 1'b1; @(negedge clk);
  endtask

  task automatic t_gaps;
    do_reset(1'b0, 8'd1);
    send_bits(WIN - 1, 0, -1, 1); chk("R2 one bit short", ais, 1'b0);
    send_bits(1, 0, -1, 0);       chk("R2 last enabled bit closes", ais, 1'b1);
  endtask

  task automatic t_tx;
    tx_en = 1'b0; tx_d = 1'b0; #1; chk("R9 pass 0", tx_q, 1'b0);
    tx_d = 1'b1; #1; chk("R9 pass 1", tx_q, 1'b1);
    tx_en = 1'b1; tx_d = 1'b0; #1; chk("R9 forced", tx_q, 1'b1);
    tx_d = 1'b1; #1; chk("R9 forced 1", tx_q, 1'b1);
    tx_en = 1'b0; tx_d = 1'b0; #1; chk("R9 release", tx_q, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_thr3();
    t_thr9();
    t_inframe();
    t_gaps();
    @(negedge clk);
    t_tx();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule